// File: doc/BRIEF.md
# Pulse-Width Symbol Frame Decoder

This block receives a single-wire line on which every bit slot carries one active-high pulse, and the length of that pulse alone carries the meaning. Each pulse is timed with a counter in units of one sixteenth of the nominal bit period. The measured length is sorted into one of three classes: a short sync pulse, a medium zero or a long one. Any other length is flagged as malformed. The windows are wide enough to cover a bit rate anywhere from 1164 to 1236 bit/s, which is 1200 bit/s ±3%.

A sync opens a frame of 19 slots. The 18 data slots that follow are shifted into a register, and when the last one arrives the whole word is presented together with a one-cycle valid strobe. A malformed pulse, or a data bit that arrives while no frame is open, raises the error strobe. A malformed pulse also throws away any partly assembled word. Every decoded pulse also produces a symbol strobe carrying its class. This lets a host follow the line pulse by pulse.

The line input may be asynchronous to the clock. It passes through a two-flop synchroniser before edges are detected. The analog receiver and any interrupt handling sit outside the block.

Top module: `pwd_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, frame_o, frame_vld_o, sym_stb_o, sym_o and err_o are all zero.
- R2: The width of a pulse is floor(H / CLK_PER_TICK) ticks, where H is the number of clock cycles the line is high. A width of 1 to 3 ticks is reported as sync, sym_o = 2'b00.
- R3: A width of 5 to 8 ticks is reported as a zero, sym_o = 2'b01. A width of 10 to 14 ticks is reported as a one, sym_o = 2'b10.
- R4: Any other width (0, 4, 9 or 15 and above) is reported with sym_o = 2'b11, and err_o pulses in the same cycle as the symbol strobe.
- R5: The tick counter saturates at its all-ones value (31 with TICK_W = 5). A very long pulse is therefore reported as malformed and never wraps back into a valid window.
- R6: After a sync, the 18th data bit makes frame_vld_o pulse for one cycle. At that point frame_o holds the word, with the first received bit in bit 17 and the last in bit 0. frame_o keeps its value at all other times.
- R7: A sync that arrives while a frame is partly assembled restarts assembly from zero bits, and it does not raise err_o.
- R8: A data bit that arrives while no frame is open is dropped and pulses err_o. No frame is open before the first sync, or after a frame has completed and no new sync has come.
- R9: A malformed pulse discards the partial frame. Data bits after it raise err_o until the next sync, and no frame_vld_o results from the discarded bits.
- R10: Each pulse on line_i produces exactly one sym_stb_o cycle, within five clock cycles of its falling edge. No other sym_stb_o cycles occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial line, active-high pulses, asynchronous |
| frame_o | output | DATA_BITS | Last completed frame word, first bit in the MSB |
| frame_vld_o | output | 1 | One-cycle strobe when frame_o is updated |
| sym_stb_o | output | 1 | One-cycle strobe per decoded pulse |
| sym_o | output | 2 | Class of the last pulse: 00 sync, 01 zero, 10 one, 11 malformed |
| err_o | output | 1 | One-cycle strobe on a malformed pulse or a data bit with no open frame |

## Verification
The hardest situation to reach from the ports is a tick counter that would wrap into a valid window. It needs a single pulse of hundreds of ticks, chosen so that its length modulo 32 lands inside the one window. The bench drives a directed 300-tick pulse to reach it. The interaction of malformed pulses, early syncs and orphan data bits with a partly built word is also hard to hit by chance. The random phase therefore injects these events with set probabilities into otherwise well-formed frames, and a bench model tracks the expected frame state.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {
    SYM_SYNC = 2'b00,
    SYM_ZERO = 2'b01,
    SYM_ONE  = 2'b10,
    SYM_BAD  = 2'b11
  } sym_e;
endpackage

// File: rtl/pwd_line_sync.sv
module pwd_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign level_o = stab_q;
  assign rise_o  = stab_q & ~prev_q;
  assign fall_o  = ~stab_q & prev_q;
endmodule

// File: rtl/pwd_width_meter.sv
module pwd_width_meter #(
  parameter int CLK_PER_TICK = 10417,
  parameter int TICK_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              level_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              done_o,
  output logic [TICK_W-1:0] ticks_o
);
  localparam int PRE_W = $clog2(CLK_PER_TICK + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(CLK_PER_TICK);
  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic [PRE_W-1:0]  pre_q, pre_base, pre_nxt;
  logic [TICK_W-1:0] tick_q, tick_base;
  logic              done_q;
  logic [TICK_W-1:0] ticks_q;

  always_comb begin
    pre_base  = rise_i ? '0 : pre_q;
    tick_base = rise_i ? '0 : tick_q;
    pre_nxt   = pre_base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      tick_q  <= '0;
      done_q  <= 1'b0;
      ticks_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (level_i) begin
        if (pre_nxt == PRE_LAST) begin
          pre_q  <= '0;
          tick_q <= (tick_base == TICK_MAX) ? tick_base : tick_base + 1'b1;
        end else begin
          pre_q  <= pre_nxt;
          tick_q <= tick_base;
        end
      end
      if (fall_i) begin
        done_q  <= 1'b1;
        ticks_q <= tick_q;
      end
    end
  end

  assign done_o  = done_q;
  assign ticks_o = ticks_q;
endmodule

// File: rtl/pwd_classifier.sv
module pwd_classifier
  import pwd_pkg::*;
#(
  parameter int TICK_W   = 5,
  parameter int SYNC_LO  = 1,
  parameter int SYNC_HI  = 3,
  parameter int ZERO_LO  = 5,
  parameter int ZERO_HI  = 8,
  parameter int ONE_LO   = 10,
  parameter int ONE_HI   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic              vld_o,
  output sym_e              sym_o
);
  function automatic logic in_win(input logic [TICK_W-1:0] t, input int lo, input int hi);
    return (int'(t) >= lo) && (int'(t) <= hi);
  endfunction

  sym_e cls;

  always_comb begin
    if (in_win(ticks_i, SYNC_LO, SYNC_HI))      cls = SYM_SYNC;
    else if (in_win(ticks_i, ZERO_LO, ZERO_HI)) cls = SYM_ZERO;
    else if (in_win(ticks_i, ONE_LO, ONE_HI))   cls = SYM_ONE;
    else                                        cls = SYM_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      sym_o <= SYM_SYNC;
    end else begin
      vld_o <= done_i;
      if (done_i) sym_o <= cls;
    end
  end
endmodule

// File: rtl/pwd_frame_builder.sv
module pwd_frame_builder
  import pwd_pkg::*;
#(
  parameter int DATA_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  sym_e                 sym_i,
  output logic [DATA_BITS-1:0] frame_o,
  output logic                 frame_vld_o,
  output logic                 sym_stb_o,
  output logic [1:0]           sym_o,
  output logic                 err_o
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_BITS - 1);

  logic                 armed_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [DATA_BITS-1:0] shift_q;
  logic [DATA_BITS-1:0] shift_nxt;
  logic                 bit_val;

  assign bit_val   = (sym_i == SYM_ONE);
  assign shift_nxt = {shift_q[DATA_BITS-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      shift_q     <= '0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
      sym_stb_o   <= 1'b0;
      sym_o       <= 2'b00;
      err_o       <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      err_o       <= 1'b0;
      sym_stb_o   <= vld_i;
      if (vld_i) begin
        sym_o <= sym_i;
        case (sym_i)
          SYM_SYNC: begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
          end
          SYM_BAD: begin
            armed_q <= 1'b0;
            err_o   <= 1'b1;
          end
          default: begin
            if (!armed_q) begin
              err_o <= 1'b1;
            end else begin
              shift_q <= shift_nxt;
              if (cnt_q == CNT_LAST) begin
                frame_o     <= shift_nxt;
                frame_vld_o <= 1'b1;
                armed_q     <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pwd_decoder.sv
module pwd_decoder
  import pwd_pkg::*;
#(
  parameter int CLK_PER_TICK = 10417,
  parameter int TICK_W       = 5,
  parameter int DATA_BITS    = 18,
  parameter int SYNC_LO      = 1,
  parameter int SYNC_HI      = 3,
  parameter int ZERO_LO      = 5,
  parameter int ZERO_HI      = 8,
  parameter int ONE_LO       = 10,
  parameter int ONE_HI       = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] frame_o,
  output logic                 frame_vld_o,
  output logic                 sym_stb_o,
  output logic [1:0]           sym_o,
  output logic                 err_o
);
  logic              level, rise, fall;
  logic              meas_done;
  logic [TICK_W-1:0] meas_ticks;
  logic              cls_vld;
  sym_e              cls_sym;

  pwd_line_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  pwd_width_meter #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .TICK_W       (TICK_W)
  ) u_meter (
    .clk     (clk),
    .rst     (rst),
    .level_i (level),
    .rise_i  (rise),
    .fall_i  (fall),
    .done_o  (meas_done),
    .ticks_o (meas_ticks)
  );

  pwd_classifier #(
    .TICK_W  (TICK_W),
    .SYNC_LO (SYNC_LO),
    .SYNC_HI (SYNC_HI),
    .ZERO_LO (ZERO_LO),
    .ZERO_HI (ZERO_HI),
    .ONE_LO  (ONE_LO),
    .ONE_HI  (ONE_HI)
  ) u_cls (
    .clk     (clk),
    .rst     (rst),
    .done_i  (meas_done),
    .ticks_i (meas_ticks),
    .vld_o   (cls_vld),
    .sym_o   (cls_sym)
  );

  pwd_frame_builder #(
    .DATA_BITS (DATA_BITS)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .vld_i       (cls_vld),
    .sym_i       (cls_sym),
    .frame_o     (frame_o),
    .frame_vld_o (frame_vld_o),
    .sym_stb_o   (sym_stb_o),
    .sym_o       (sym_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/pwd_decoder_chk.sv
module pwd_decoder_chk #(
  parameter int DATA_BITS = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] frame_o,
  input logic                 frame_vld_o,
  input logic                 sym_stb_o,
  input logic [1:0]           sym_o,
  input logic                 err_o
);
  // R6
  frame_on_data_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld_o |-> (sym_stb_o && (sym_o == 2'b01 || sym_o == 2'b10)));
  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_vld_o |-> $stable(frame_o));
  // R4
  bad_sym_err_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_stb_o && sym_o == 2'b11) |-> err_o);
  // R8
  err_with_stb_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (sym_stb_o && !frame_vld_o && sym_o != 2'b00));
  // R10
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    sym_stb_o |=> !sym_stb_o);
endmodule

bind pwd_decoder pwd_decoder_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_o     (frame_o),
  .frame_vld_o (frame_vld_o),
  .sym_stb_o   (sym_stb_o),
  .sym_o       (sym_o),
  .err_o       (err_o)
);

// File: tb/tb_pwd_decoder.sv
`timescale 1ns/1ps
module tb_pwd_decoder;
  localparam int CPT  = 4;
  localparam int DB   = 18;
  localparam int TMAX = 31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_i = 1'b0;
  logic [DB-1:0] frame_o;
  logic          frame_vld_o, sym_stb_o, err_o;
  logic [1:0]    sym_o;

  always #2.5 clk = ~clk;

  pwd_decoder #(.CLK_PER_TICK(CPT), .TICK_W(5), .DATA_BITS(DB)) dut (
    .clk(clk), .rst(rst), .line_i(line_i), .frame_o(frame_o),
    .frame_vld_o(frame_vld_o), .sym_stb_o(sym_stb_o), .sym_o(sym_o), .err_o(err_o)
  );

  int checks = 0, failures = 0;
  int n_sym = 0, n_err = 0, n_frame = 0;
  logic [DB-1:0] got_frame = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (sym_stb_o)   n_sym++;
      if (err_o)       n_err++;
      if (frame_vld_o) begin n_frame++; got_frame = frame_o; end
    end
  end

  // bench model
  bit            m_armed = 0;
  int            m_cnt = 0;
  logic [DB-1:0] m_shift = '0, m_frame = '0;
  int            e_sym = 0, e_err = 0, e_frame = 0;
  logic [1:0]    e_code = 2'b00;

  function automatic logic [1:0] classify(input int t);
    if (t >= 1 && t <= 3)   return 2'b00;
    if (t >= 5 && t <= 8)   return 2'b01;
    if (t >= 10 && t <= 14) return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int ticks, input string req);
    int t;
    logic [1:0] c;
    @(negedge clk) line_i = 1'b1;
    repeat (ticks * CPT + CPT / 2) @(negedge clk);
    line_i = 1'b0;
    repeat (8 * CPT + 10) @(negedge clk);
    t = (ticks > TMAX) ? TMAX : ticks;
    c = classify(t);
    e_sym++;
    e_code = c;
    if (c == 2'b11) begin
      e_err++; m_armed = 0;
    end else if (c == 2'b00) begin
      m_armed = 1; m_cnt = 0;
    end else if (!m_armed) begin
      e_err++;
    end else begin
      m_shift = {m_shift[DB-2:0], c == 2'b10};
      if (m_cnt == DB - 1) begin
        e_frame++; m_frame = m_shift; m_armed = 0;
      end else m_cnt++;
    end
    check(req, "symbol count", n_sym, e_sym);
    check(req, "symbol class", int'(sym_o), int'(e_code));
    check(req, "error count", n_err, e_err);
    check(req, "frame count", n_frame, e_frame);
    check(req, "frame word", int'(frame_o), int'(m_frame));
  endtask

  function automatic int width_for(input bit b, input int sel);
    if (b) return 10 + (sel % 5);
    return 5 + (sel % 4);
  endfunction

  task automatic send_bits(input logic [DB-1:0] w, input int nb, input string req);
    for (int i = DB - 1; i >= DB - nb; i--) pulse(width_for(w[i], i), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    check("R1", "frame_o in reset", int'(frame_o), 0);
    check("R1", "outputs in reset", int'({frame_vld_o, sym_stb_o, sym_o, err_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "outputs after reset", int'({frame_vld_o, sym_stb_o, sym_o, err_o, frame_o}), 0);

    pulse(6, "R8 data before sync");
    pulse(1, "R2 sync low edge");
    send_bits(18'h2A5C3, DB, "R6 frame R3 windows");
    pulse(12, "R8 data after frame");
    pulse(3, "R2 sync high edge");
    send_bits(18'h3FFFF, 5, "R3 partial");
    pulse(2, "R7 resync");
    send_bits(18'h0F0F0, DB, "R7 frame after resync");
    pulse(2, "R2 sync");
    pulse(5, "R3 zero low"); pulse(8, "R3 zero high");
    pulse(10, "R3 one low"); pulse(14, "R3 one high");
    pulse(9, "R4 gap width");
    pulse(11, "R9 orphan after bad");
    pulse(4, "R4 width 4");
    pulse(15, "R4 width 15");
    pulse(0, "R4 width 0");
    pulse(2, "R9 resume");
    send_bits(18'h15555, DB, "R9 frame after bad");
    pulse(1, "R5 sync");
    pulse(300, "R5 saturating width");
    pulse(7, "R5 orphan after saturation");

    for (int k = 0; k < 300; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 4)       pulse($urandom_range(15, 40), "R4 random bad");
      else if (r < 7)  pulse(4 + 5 * $urandom_range(0, 1), "R4 random gap");
      else if (r < 16) pulse($urandom_range(1, 3), "R10 random sync");
      else if (r < 58) pulse($urandom_range(5, 8), "R10 random zero");
      else             pulse($urandom_range(10, 14), "R10 random one");
      if (!m_armed && $urandom_range(0, 3) != 0) pulse($urandom_range(1, 3), "R6 random sync");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule